// File: doc/BRIEF.md
# Crosspoint Selection Loader

This block fills the selection registers of a 16-output crosspoint switch from a small external memory. A rising edge on the load input starts a run. The block then places memory addresses 0, 1, 2 and 3 on a two-bit address output, one address per clock, and takes in one 16-bit word per clock. The data is bit-sliced. Bit n of every word belongs to output n. Successive words supply successive select bits, least significant first, so four words give every output a complete four-bit input index.

Two commit styles are provided. In automatic mode, the block raises a one-cycle commit pulse right after the fourth word. The committed selection array is copied from that pulse. In strobe mode, the filled array waits until an external active-low configure line falls. A ready flag tells the host that a run has ended. The address bus has its own enable, so several devices can share the memory lines.

Top module: `xcfg_loader`

## Requirements
- R1: While reset is asserted, every select reads 0 (all outputs take input 0), ready is low, commit is low and the memory address is 0.
- R2: A run starts only on a rising edge of `load` sampled while `ld_mode` is high. A rising edge seen while `ld_mode` is low changes neither the address, ready, commit nor the selects.
- R3: After the start edge, `mem_addr` reads 0, 1, 2 and 3 in four consecutive cycles. It then returns to 0 and holds there until the next start.
- R4: The word present while `mem_addr` reads k supplies bit k of every select. Bit n of that word goes to output n, and output n's select sits at `sel_bus[4n+3:4n]`.
- R5: Ready is low in the cycle after a start edge.
- R6: With `auto_cfg` high, `commit` is high for exactly one cycle, which is the cycle after address 3 was presented. `sel_bus` takes the new array at the end of that cycle, and ready is high from the following cycle.
- R7: With `auto_cfg` low, ready goes high in the cycle after address 3 and `sel_bus` keeps its old value. A falling edge of `cfg_n` while idle then gives a one-cycle `commit` with ready low. After that cycle, `sel_bus` holds the new array and ready is high.
- R8: With `auto_cfg` high, a falling edge of `cfg_n` raises no commit and changes neither ready nor the selects.
- R9: `mem_addr_oe` is high exactly when `addr_en_n` is low.
- R10: A start edge that arrives during a run restarts addressing at 0. The four words that follow replace the partial fill.
- R11: If a start edge coincides with an automatic commit cycle, the previously filled array is committed, ready stays low and the new run proceeds normally.
- R12: Between commit pulses `sel_bus` does not change, so all paths keep their connection while a new array is being filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_mode | input | 1 | High enables memory-driven loading |
| load | input | 1 | Rising edge starts a run |
| auto_cfg | input | 1 | High: automatic commit; low: wait for strobe |
| cfg_n | input | 1 | External active-low configure strobe |
| addr_en_n | input | 1 | Low enables the address outputs |
| mem_word | input | 16 | Data word read from the memory |
| mem_addr | output | 2 | Memory word address |
| mem_addr_oe | output | 1 | Drive enable for `mem_addr` |
| ready | output | 1 | Run finished / committed flag |
| commit | output | 1 | One-cycle pulse that carries `sel_bus` to the switch |
| sel_bus | output | 64 | Sixteen 4-bit selects, output n at bits [4n+3:4n] |

## Verification
The commit of a completed fill and the start of a new run can land in the same clock. The bench provokes this by raising `load` while the automatic commit pulse is visible, so the start edge and the commit share one edge. The bench then expects the old array to come out of the scoreboard on that commit, ready to stay low, and the new array to arrive on the next pulse. A restart in the middle of a run is also checked, with the memory contents swapped, to show that no stale bit survives.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_FILL = 1'b1
  } xcfg_phase_e;

  // next word index, wrapping to zero after the last one
  function automatic int unsigned next_index(input int unsigned cur,
                                             input int unsigned last);
    return (cur == last) ? 0 : cur + 1;
  endfunction

  // position of select bit `bitpos` of output `port` in the flat bus
  function automatic int unsigned flat_pos(input int unsigned port,
                                           input int unsigned bitpos,
                                           input int unsigned sel_w);
    return port * sel_w + bitpos;
  endfunction

endpackage

// File: rtl/xcfg_addr_seq.sv
module xcfg_addr_seq
  import xcfg_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] idx,
  output logic          filling,
  output logic          shift_en,
  output logic          last_word
);
  localparam int unsigned LAST = WORDS - 1;

  xcfg_phase_e   phase_q;
  logic [AW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else if (start) begin
      phase_q <= PH_FILL;
      idx_q   <= '0;
    end else if (phase_q == PH_FILL) begin
      idx_q <= AW'(next_index(int'(idx_q), LAST));
      if (int'(idx_q) == LAST) phase_q <= PH_IDLE;
    end
  end

  assign idx       = idx_q;
  assign filling   = (phase_q == PH_FILL);
  assign shift_en  = filling && !start;
  assign last_word = shift_en && (int'(idx_q) == LAST);

  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !last_word) |=> (idx == $past(idx) + 1'b1)); // R3
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> (idx == '0 && !shift_en)); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (idx == '0 && filling)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!filling && !start) |=> $stable(idx)); // R3

endmodule

// File: rtl/xcfg_slice_shift.sv
module xcfg_slice_shift
  import xcfg_pkg::*;
#(
  parameter int PORTS = 16,
  parameter int SEL_W = 4,
  localparam int FLAT = PORTS * SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [PORTS-1:0] word,
  output logic [FLAT-1:0]  staged
);

  // one shift register per output; a new bit enters at the top, so the
  // first word in time ends up in bit 0 after SEL_W shifts
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [SEL_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr_q <= '0;
      else if (shift_en) sr_q <= {word[p], sr_q[SEL_W-1:1]};
    end

    assign staged[flat_pos(p, SEL_W - 1, SEL_W) -: SEL_W] = sr_q;
  end

  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(staged)); // R4
  AST_STAGE_ENTRY0: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (staged[SEL_W-1] == $past(word[0]))); // R4

endmodule

// File: rtl/xcfg_commit.sv
module xcfg_commit #(
  parameter int FLAT = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            last_word,
  input  logic            auto_mode,
  input  logic            ext_take,
  input  logic [FLAT-1:0] staged,
  output logic            commit,
  output logic            ready,
  output logic [FLAT-1:0] sel
);
  logic            commit_q;
  logic            ready_q;
  logic [FLAT-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      ready_q  <= 1'b0;
      sel_q    <= '0;
    end else begin
      commit_q <= (last_word && auto_mode) || ext_take;
      if (commit_q) sel_q <= staged;
      if (start || ext_take)           ready_q <= 1'b0;
      else if (commit_q)               ready_q <= 1'b1;
      else if (last_word && !auto_mode) ready_q <= 1'b1;
    end
  end

  assign commit = commit_q;
  assign ready  = ready_q;
  assign sel    = sel_q;

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R6
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sel)); // R12
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready); // R5
  AST_READY_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !start) |=> ready); // R6
  AST_LOADED_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (sel == $past(staged))); // R4

endmodule

// File: rtl/xcfg_loader.sv
module xcfg_loader
  import xcfg_pkg::*;
#(
  parameter int PORTS = 16,
  parameter int SEL_W = 4,
  localparam int AW   = (SEL_W > 1) ? $clog2(SEL_W) : 1,
  localparam int FLAT = PORTS * SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_mode,
  input  logic             load,
  input  logic             auto_cfg,
  input  logic             cfg_n,
  input  logic             addr_en_n,
  input  logic [PORTS-1:0] mem_word,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_addr_oe,
  output logic             ready,
  output logic             commit,
  output logic [FLAT-1:0]  sel_bus
);
  logic load_q;
  logic cfg_q;
  logic start;
  logic strobe_fall;
  logic ext_take;
  logic filling;
  logic shift_en;
  logic last_word;
  logic [FLAT-1:0] staged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      cfg_q  <= 1'b1;
    end else begin
      load_q <= load;
      cfg_q  <= cfg_n;
    end
  end

  // named internal events
  assign start       = ld_mode && load && !load_q;
  assign strobe_fall = cfg_q && !cfg_n;
  assign ext_take    = strobe_fall && !auto_cfg && !filling;

  xcfg_addr_seq #(.WORDS(SEL_W), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .idx       (mem_addr),
    .filling   (filling),
    .shift_en  (shift_en),
    .last_word (last_word)
  );

  xcfg_slice_shift #(.PORTS(PORTS), .SEL_W(SEL_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .word     (mem_word),
    .staged   (staged)
  );

  xcfg_commit #(.FLAT(FLAT)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .last_word (last_word),
    .auto_mode (auto_cfg),
    .ext_take  (ext_take),
    .staged    (staged),
    .commit    (commit),
    .ready     (ready),
    .sel       (sel_bus)
  );

  assign mem_addr_oe = !addr_en_n;

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_mode && !filling) |=> !filling); // R2
  AST_AUTO_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cfg && !last_word) |=> !commit); // R8
  AST_STROBE_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ext_take |=> (commit && !ready)); // R7

endmodule

// File: tb/xcfg_loader_test.sv
module xcfg_loader_test;
  logic        clk = 1'b0;
  logic        rst_n, ld_mode, load, auto_cfg, cfg_n, addr_en_n;
  logic [15:0] mem_word;
  logic [1:0]  mem_addr;
  logic        mem_addr_oe, ready, commit;
  logic [63:0] sel_bus;

  logic [15:0] words [4];
  logic [63:0] expq [$];
  int          checks = 0;
  int          fails  = 0;
  bit          pend   = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  assign mem_word = words[mem_addr];

  xcfg_loader uut (
    .clk(clk), .rst_n(rst_n), .ld_mode(ld_mode), .load(load),
    .auto_cfg(auto_cfg), .cfg_n(cfg_n), .addr_en_n(addr_en_n),
    .mem_word(mem_word), .mem_addr(mem_addr), .mem_addr_oe(mem_addr_oe),
    .ready(ready), .commit(commit), .sel_bus(sel_bus)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected array restated from R4: select of output o gathers bit o of words 0..3
  function automatic logic [63:0] gather();
    logic [63:0] r = '0;
    for (int o = 0; o < 16; o++)
      for (int k = 0; k < 4; k++)
        r[o*4 + k] = words[k][o];
    return r;
  endfunction

  task automatic set_words(input logic [15:0] a, b, c, d);
    words[0] = a; words[1] = b; words[2] = c; words[3] = d;
  endtask

  // raise load; returns just after the start edge
  task automatic start_run();
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    chk("R5 ready low after start", 64'(ready), 64'd0);
    chk("R3 first address", 64'(mem_addr), 64'd0);
  endtask

  // returns just after the edge that consumed address 3
  task automatic run_fill();
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk("R3 address step", 64'(mem_addr), 64'(k));
    end
    @(negedge clk);
    chk("R3 address wrap", 64'(mem_addr), 64'd0);
  endtask

  // scoreboard monitor: one cycle after each commit pulse, sel_bus must match
  always @(negedge clk) begin
    if (pend) begin
      if (expq.size() == 0) chk("R6 unexpected commit", 64'd1, 64'd0);
      else chk("R4 committed array", sel_bus, expq.pop_front());
    end
    pend = (commit === 1'b1);
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] e1, e2;
    rst_n = 1'b0; ld_mode = 1'b1; load = 1'b0; auto_cfg = 1'b1;
    cfg_n = 1'b1; addr_en_n = 1'b0;
    set_words(16'h0000, 16'h0000, 16'h0000, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R1 reset selects", sel_bus, 64'd0);
    chk("R1 reset ready", 64'(ready), 64'd0);
    chk("R1 reset commit", 64'(commit), 64'd0);
    chk("R1 reset address", 64'(mem_addr), 64'd0);
    rst_n = 1'b1;

    // R9 address drive enable
    addr_en_n = 1'b1; #1;
    chk("R9 address released", 64'(mem_addr_oe), 64'd0);
    addr_en_n = 1'b0; #1;
    chk("R9 address driven", 64'(mem_addr_oe), 64'd1);

    // R6 automatic commit
    set_words(16'hA5C3, 16'h3C0F, 16'hF00D, 16'h1248);
    e1 = gather(); expq.push_back(e1);
    start_run(); run_fill();
    chk("R6 pulse after last word", 64'(commit), 64'd1);
    chk("R6 ready low during pulse", 64'(ready), 64'd0);
    chk("R12 old array during pulse", sel_bus, 64'd0);
    @(negedge clk);
    chk("R6 pulse one cycle", 64'(commit), 64'd0);
    chk("R6 ready after pulse", 64'(ready), 64'd1);
    chk("R3 address held", 64'(mem_addr), 64'd0);

    // R2 load ignored while ld_mode low
    ld_mode = 1'b0;
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 address unchanged", 64'(mem_addr), 64'd0);
    chk("R2 ready unchanged", 64'(ready), 64'd1);
    chk("R2 no commit", 64'(commit), 64'd0);
    chk("R2 selects unchanged", sel_bus, e1);
    ld_mode = 1'b1;

    // R8 strobe ignored in automatic mode
    @(negedge clk) cfg_n = 1'b0;
    @(negedge clk) cfg_n = 1'b1;
    chk("R8 no commit", 64'(commit), 64'd0);
    chk("R8 ready kept", 64'(ready), 64'd1);
    @(negedge clk);
    chk("R8 no late commit", 64'(commit), 64'd0);
    chk("R8 selects kept", sel_bus, e1);

    // R7 strobe mode
    auto_cfg = 1'b0;
    set_words(16'h8001, 16'h7FFE, 16'h5555, 16'hCAFE);
    e2 = gather();
    start_run(); run_fill();
    chk("R7 ready after fill", 64'(ready), 64'd1);
    chk("R7 no auto pulse", 64'(commit), 64'd0);
    repeat (3) @(negedge clk);
    chk("R7 selects wait for strobe", sel_bus, e1);
    expq.push_back(e2);
    cfg_n = 1'b0;
    @(negedge clk);
    chk("R7 strobe pulse", 64'(commit), 64'd1);
    chk("R7 ready low on strobe", 64'(ready), 64'd0);
    cfg_n = 1'b1;
    @(negedge clk);
    chk("R7 pulse one cycle", 64'(commit), 64'd0);
    chk("R7 ready after strobe", 64'(ready), 64'd1);

    // R10 restart mid-run with new memory contents
    auto_cfg = 1'b1;
    set_words(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    start_run();
    @(negedge clk);
    chk("R3 address step", 64'(mem_addr), 64'd1);
    set_words(16'h0F0F, 16'h00FF, 16'h3333, 16'h9669);
    expq.push_back(gather());
    load = 1'b1;
    @(negedge clk) load = 1'b0;
    chk("R10 address restarted", 64'(mem_addr), 64'd0);
    chk("R10 ready low", 64'(ready), 64'd0);
    run_fill();
    chk("R10 pulse after refill", 64'(commit), 64'd1);
    @(negedge clk);
    chk("R10 ready after refill", 64'(ready), 64'd1);

    // R11 start edge in the commit cycle
    set_words(16'h1357, 16'h2468, 16'hACE0, 16'hBDF1);
    expq.push_back(gather());
    start_run(); run_fill();
    chk("R11 pulse present", 64'(commit), 64'd1);
    set_words(16'hE7E7, 16'h1818, 16'h6006, 16'h0990);
    expq.push_back(gather());
    load = 1'b1;
    @(negedge clk) load = 1'b0;
    chk("R11 ready stays low", 64'(ready), 64'd0);
    chk("R11 new run at address 0", 64'(mem_addr), 64'd0);
    chk("R11 pulse ended", 64'(commit), 64'd0);
    run_fill();
    chk("R11 second pulse", 64'(commit), 64'd1);
    @(negedge clk);
    chk("R11 ready after second pulse", 64'(ready), 64'd1);
    @(negedge clk);
    chk("R6 every expected commit seen", 64'(expq.size()), 64'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule